// File: doc/BRIEF.md
# Eight-Operation Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit. It takes two unsigned operands of width `W` and a 3-bit operation code, and returns a `W`-bit result with three status flags. The operations are add, subtract, invert, AND, OR, XOR, a conditional pass ("zero when the first operand is below the second, otherwise the first operand") and a logical left shift. Add and subtract use one shared adder. Subtraction feeds the adder the inverted second operand and forces its carry-in high. The conditional pass reuses the same adder in subtract mode to decide the unsigned comparison.

A surrounding datapath drives the operands and the code and reads the result in the same cycle. Any registering belongs to the user of the block. There are no states and no transitions: the block is a single decode from operation code to output.

Top module: `alu8fn`

## Requirements
- R1: Code 0 (add) gives result = (A + B) mod 2^W, and carry_flag equals bit W of the full sum.
- R2: Code 1 (subtract) gives result = (A − B) mod 2^W, and carry_flag is 1 exactly when A ≥ B unsigned (no borrow).
- R3: Code 2 gives result = bitwise NOT of A.
- R4: Codes 3, 4 and 5 give A AND B, A OR B and A XOR B, in that order.
- R5: Code 6 gives zero when A < B under an unsigned compare, and otherwise gives A.
- R6: Code 7 gives A shifted left logically by the unsigned value of B, with zeros filling from the right. Any B of W or more gives zero.
- R7: zero_flag is 1 exactly when the result is all zeros.
- R8: pos_flag is 1 exactly when the result is nonzero under an unsigned reading, so exactly one of zero_flag and pos_flag is set.
- R9: carry_flag is 0 for codes 2 through 7.
- R10: All outputs follow the inputs with no clock, and hold no value from earlier inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | First operand (unsigned) |
| opnd_b | input | W | Second operand, or the shift amount for code 7 |
| op_sel | input | 3 | Operation code 0..7 |
| result | output | W | Operation result |
| zero_flag | output | 1 | Result is all zeros |
| pos_flag | output | 1 | Result is nonzero |
| carry_flag | output | 1 | Adder carry-out for codes 0 and 1, otherwise 0 |

## Verification
Because the block holds no state, a fault in it cannot surface later. It shows at the ports for the same input combination that triggers it, as a wrong result bit or a wrong flag. A swapped adder polarity shows up in the carry or in the conditional pass at the boundary where A equals B. A shifter fault shows up at B equal to W−1 or W. The bench sweeps every code against every operand pair of a 4-bit instance, so each such fault meets an input that exposes it.

// File: rtl/alu8fn_pkg.sv
package alu8fn_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_INV   = 3'd2,
        OP_AND   = 3'd3,
        OP_OR    = 3'd4,
        OP_XOR   = 3'd5,
        OP_CLAMP = 3'd6,
        OP_SHL   = 3'd7
    } alu_op_e;
endpackage

// File: rtl/alu8fn_addsub.sv
module alu8fn_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    always_comb begin
        b_eff = b ^ {W{sub}};
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = full[W-1:0];
        cout  = full[W];
    end
endmodule

// File: rtl/alu8fn_bitwise.sv
module alu8fn_bitwise #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y_inv,
    output logic [W-1:0] y_and,
    output logic [W-1:0] y_or,
    output logic [W-1:0] y_xor
);
    always_comb begin
        y_inv = ~a;
        y_and = a & b;
        y_or  = a | b;
        y_xor = a ^ b;
    end
endmodule

// File: rtl/alu8fn_lshift.sv
module alu8fn_lshift #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] amt,
    output logic [W-1:0] y
);
    localparam int SHW = (W > 1) ? $clog2(W) : 1;
    localparam logic [W:0] W_VAL = (W + 1)'(W);

    logic too_far;

    always_comb begin
        too_far = ({1'b0, amt} >= W_VAL);
        y       = too_far ? '0 : (a << amt[SHW-1:0]);
    end
endmodule

// File: rtl/alu8fn.sv
module alu8fn
    import alu8fn_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [2:0]   op_sel,
    output logic [W-1:0] result,
    output logic         zero_flag,
    output logic         pos_flag,
    output logic         carry_flag
);
    alu_op_e      op;
    logic         sub_mode;
    logic [W-1:0] sum;
    logic         cout;
    logic [W-1:0] y_inv, y_and, y_or, y_xor, y_shl;

    assign op       = alu_op_e'(op_sel);
    assign sub_mode = (op == OP_SUB) || (op == OP_CLAMP);

    alu8fn_addsub #(.W(W)) u_addsub (
        .a(opnd_a), .b(opnd_b), .sub(sub_mode), .sum(sum), .cout(cout)
    );

    alu8fn_bitwise #(.W(W)) u_bitwise (
        .a(opnd_a), .b(opnd_b),
        .y_inv(y_inv), .y_and(y_and), .y_or(y_or), .y_xor(y_xor)
    );

    alu8fn_lshift #(.W(W)) u_lshift (
        .a(opnd_a), .amt(opnd_b), .y(y_shl)
    );

    // Result select; in subtract mode cout = 0 means a borrow, i.e. A < B.
    always_comb begin
        result     = '0;
        carry_flag = 1'b0;
        unique case (op)
            OP_ADD:   begin result = sum; carry_flag = cout; end
            OP_SUB:   begin result = sum; carry_flag = cout; end
            OP_INV:   result = y_inv;
            OP_AND:   result = y_and;
            OP_OR:    result = y_or;
            OP_XOR:   result = y_xor;
            OP_CLAMP: result = cout ? opnd_a : '0;
            OP_SHL:   result = y_shl;
            default:  result = '0;
        endcase
    end

    assign zero_flag = ~|result;
    assign pos_flag  = |result;
endmodule

// File: rtl/alu8fn_chk.sv
module alu8fn_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [2:0]   op_sel,
    input logic [W-1:0] result,
    input logic         zero_flag,
    input logic         pos_flag,
    input logic         carry_flag
);
    logic known;
    assign known = !$isunknown({opnd_a, opnd_b, op_sel});

    always_comb begin
        if (known) begin
            // R8: exactly one of the two result flags
            a_r8_flags_exclusive: assert ($onehot({zero_flag, pos_flag}));
            // R9: carry idle outside add/subtract
            if (op_sel >= 3'd2)
                a_r9_carry_idle: assert (carry_flag == 1'b0);
            // R2: no-borrow carry on subtract
            if (op_sel == 3'd1)
                a_r2_sub_borrow: assert (carry_flag == (opnd_a >= opnd_b));
            // R3: inverted operand
            if (op_sel == 3'd2)
                a_r3_invert: assert ((result ^ opnd_a) == {W{1'b1}});
            // R5: conditional pass yields zero or A
            if (op_sel == 3'd6)
                a_r5_clamp: assert (result == ((opnd_a < opnd_b) ? '0 : opnd_a));
            // R6: oversized shift clears
            if (op_sel == 3'd7 && {1'b0, opnd_b} >= (W + 1)'(W))
                a_r6_shift_big: assert (result == '0);
        end
    end
endmodule

bind alu8fn alu8fn_chk #(.W(W)) chk_i (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .result(result),
    .zero_flag(zero_flag), .pos_flag(pos_flag), .carry_flag(carry_flag)
);

// File: tb/alu8fn_tb_top.sv
module alu8fn_tb_top;
    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic [W-1:0] a, b;
    logic [2:0]   op;
    logic [W-1:0] result;
    logic         zf, pf, cf;
    int           n_checks = 0;
    int           n_errs   = 0;
    bit           done     = 0;

    always #10 clk = ~clk;  // 50 MHz

    alu8fn #(.W(W)) dut_i (
        .opnd_a(a), .opnd_b(b), .op_sel(op), .result(result),
        .zero_flag(zf), .pos_flag(pf), .carry_flag(cf)
    );

    task automatic check(input string req, input int act, input int exp, input int o,
                         input int x, input int y);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s op=%0d a=%0d b=%0d actual=%0d expected=%0d",
                     req, o, x, y, act, exp);
        end
    endtask

    function automatic string req_of(input int o);
        case (o)
            0: return "R1"; 1: return "R2"; 2: return "R3";
            3, 4, 5: return "R4"; 6: return "R5"; default: return "R6";
        endcase
    endfunction

    initial begin
        // R10: no clock edge needed; reset-like state with all-zero inputs
        a = '0; b = '0; op = 3'd0;
        #5;
        check("R10", result, 0, 0, 0, 0);
        check("R7", zf, 1, 0, 0, 0);
        check("R8", pf, 0, 0, 0, 0);
        for (int o = 0; o < 8; o++) begin
            for (int x = 0; x <= MASK; x++) begin
                for (int y = 0; y <= MASK; y++) begin
                    int r, c, s;
                    @(negedge clk);
                    op = o[2:0]; a = x[W-1:0]; b = y[W-1:0];
                    c = 0;
                    case (o)
                        0: begin s = x + y; r = s & MASK; c = s >> W; end
                        1: begin r = (x - y) & MASK; c = (x >= y) ? 1 : 0; end
                        2: r = ~x & MASK;
                        3: r = x & y;
                        4: r = x | y;
                        5: r = x ^ y;
                        6: r = (x < y) ? 0 : x;
                        default: r = (y >= W) ? 0 : ((x << y) & MASK);
                    endcase
                    #2;
                    check(req_of(o), result, r, o, x, y);
                    check((o < 2) ? req_of(o) : "R9", cf, c, o, x, y);
                    check("R7", zf, (r == 0) ? 1 : 0, o, x, y);
                    check("R8", pf, (r != 0) ? 1 : 0, o, x, y);
                end
            end
        end
        // R10: output follows an input change between edges
        op = 3'd0; a = 4'd3; b = 4'd4;
        #1;
        a = 4'd9;
        #1;
        check("R10", result, 13, 0, 9, 4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule